// File: doc/BRIEF.md
# Configuration Store with Security Lock

This block guards access to the configuration memory of a programmable logic device. It keeps three kinds of state: the configuration pattern (a parameterized number of words), an eight-byte user signature area for any data the user wants to keep with the device, and one security bit. A test or programming host talks to it through a command stream. Each command carries an opcode, an address and a data byte. Each command that is accepted produces exactly one response, carrying a data byte and an error flag.

The security bit is one-way in normal use. A lock command sets it, and the command accepted next already sees it. While it is set, the block refuses pattern readback (verify), pattern writes and the preloading of the device's state registers. Signature reads and writes are never refused because of the lock. The only way to clear the lock is a full erase. An erase walks the whole pattern array one word per cycle, clears it, drops the lock, and reports completion through the same response stream. A refused command changes no state. It answers with the error flag set and a data byte of zero.

The command input is a valid/ready stream, and so is the response output. The block accepts a new command only when it is idle and has no response waiting. A response, once raised, stays valid and keeps its data and error flag unchanged until the consumer asserts `rsp_ready`. While a response waits, `cmd_ready` stays low. This is how back-pressure on the output stalls the input. A consumer may keep `rsp_ready` high at all times.

Top module: `cfg_lock_store`

## Requirements
- R1: After reset the lock is clear, every pattern word, every signature byte and every preload bit is zero, no response is pending, `busy` is low and `cmd_ready` is high.
- R2: While unlocked, a pattern-write command (opcode 1) stores `cmd_wdata` at word `cmd_addr`, and a verify command (opcode 2) returns that word with the error flag clear.
- R3: A lock command (opcode 6) affects the command accepted right after it. While locked, verify returns data 0 with the error flag set, and pattern-write is refused with the error flag set.
- R4: While unlocked, a preload command (opcode 3) sets bit `cmd_addr` of `preload_q` to `cmd_wdata[0]`, leaves every other bit unchanged, and answers with the error flag clear.
- R5: While locked, a preload command is refused with the error flag set, and `preload_q` does not change.
- R6: A signature write (opcode 4) stores `cmd_wdata` at byte `cmd_addr` (0 to 7). A signature read (opcode 5) returns it. Both succeed with the error flag clear whatever the state of the lock.
- R7: An erase command (opcode 7) holds `busy` high and `cmd_ready` low for exactly one cycle per pattern word. It then clears the lock, leaves every pattern word at zero, keeps the signature and `preload_q`, and answers with data 0 and the error flag clear.
- R8: An opcode outside 1 to 7, or an address beyond the range of the target (pattern words, preload bits or signature bytes), is refused with data 0 and the error flag set, and no state changes.
- R9: While `rsp_valid` is high and `rsp_ready` is low, the response stays valid with stable data and error flag, and `cmd_ready` stays low.
- R10: For every opcode except erase, `rsp_valid` rises on the clock edge after the edge that accepts the command.
- R11: A lock command answers with the error flag clear, also when the block is already locked, and `locked` is high from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command stream valid |
| cmd_ready | output | 1 | Command stream ready |
| cmd_op | input | 4 | Opcode |
| cmd_addr | input | ADDR_W (6) | Word, preload bit or signature byte index |
| cmd_wdata | input | WORD_W (8) | Write data; bit 0 is the preload value |
| rsp_valid | output | 1 | Response stream valid |
| rsp_ready | input | 1 | Response stream ready |
| rsp_data | output | WORD_W (8) | Read data, zero for writes and refusals |
| rsp_err | output | 1 | Command refused |
| busy | output | 1 | Erase sweep in progress |
| locked | output | 1 | Security bit |
| preload_q | output | NREG (10) | Preloaded state registers |

## Verification
A wrong lock bit shows up on the next command's response. A verify either leaks data it should not, or a permitted access comes back with the error flag set, one cycle after acceptance. A miscounted erase sweep shows up as a `busy` window of the wrong length and as words that are still nonzero at the next verify. A corrupted preload or signature register appears in `preload_q` on the next cycle, or in the next signature read. The bench compares every output against a behavioural model on every cycle, so each of these faults is reported in the cycle where it first reaches a port.

// File: rtl/cfg_lock_pkg.sv
package cfg_lock_pkg;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_NONE    = 4'd0,
    OP_PAT_WR  = 4'd1,
    OP_PAT_RD  = 4'd2,
    OP_PRELOAD = 4'd3,
    OP_SIG_WR  = 4'd4,
    OP_SIG_RD  = 4'd5,
    OP_LOCK    = 4'd6,
    OP_ERASE   = 4'd7
  } op_e;

  typedef enum logic [2:0] {
    ACT_REFUSE,
    ACT_PAT_WR,
    ACT_PAT_RD,
    ACT_PRELOAD,
    ACT_SIG_WR,
    ACT_SIG_RD,
    ACT_LOCK,
    ACT_ERASE
  } act_e;

  typedef enum logic {
    ST_IDLE,
    ST_SWEEP
  } state_e;

endpackage

// File: rtl/cfg_lock_decode.sv
module cfg_lock_decode
  import cfg_lock_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int CFG_WORDS = 40,
  parameter int NREG      = 10,
  parameter int SIG_BYTES = 8
) (
  input  logic [OP_W-1:0]   op,
  input  logic [ADDR_W-1:0] addr,
  input  logic              locked,
  output act_e              act
);

  localparam logic [31:0] PAT_LIM = 32'(CFG_WORDS);
  localparam logic [31:0] REG_LIM = 32'(NREG);
  localparam logic [31:0] SIG_LIM = 32'(SIG_BYTES);

  logic [31:0] addr_w;
  logic        pat_ok;
  logic        reg_ok;
  logic        sig_ok;

  assign addr_w = 32'(addr);
  assign pat_ok = (addr_w < PAT_LIM) && !locked;
  assign reg_ok = (addr_w < REG_LIM) && !locked;
  assign sig_ok = (addr_w < SIG_LIM);

  always_comb begin
    act = ACT_REFUSE;
    case (op)
      OP_PAT_WR:  if (pat_ok) act = ACT_PAT_WR;
      OP_PAT_RD:  if (pat_ok) act = ACT_PAT_RD;
      OP_PRELOAD: if (reg_ok) act = ACT_PRELOAD;
      OP_SIG_WR:  if (sig_ok) act = ACT_SIG_WR;
      OP_SIG_RD:  if (sig_ok) act = ACT_SIG_RD;
      OP_LOCK:    act = ACT_LOCK;
      OP_ERASE:   act = ACT_ERASE;
      default:    act = ACT_REFUSE;
    endcase
  end

endmodule

// File: rtl/cfg_lock_pattern.sv
module cfg_lock_pattern #(
  parameter int WORDS  = 40,
  parameter int WORD_W = 8,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              clr_en,
  input  logic [ADDR_W-1:0] clr_addr,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data
);

  logic [WORD_W-1:0] mem [WORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < WORDS; w++) mem[w] <= '0;
    end else begin
      for (int w = 0; w < WORDS; w++) begin
        if (clr_en && clr_addr == ADDR_W'(w))
          mem[w] <= '0;
        else if (wr_en && wr_addr == ADDR_W'(w))
          mem[w] <= wr_data;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    for (int w = 0; w < WORDS; w++)
      if (rd_addr == ADDR_W'(w)) rd_data = mem[w];
  end

  // R7: the erase sweep and a command write never share a cycle
  sweep_write_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && clr_en));

endmodule

// File: rtl/cfg_lock_signature.sv
module cfg_lock_signature #(
  parameter int BYTES  = 8,
  parameter int WORD_W = 8,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_data
);

  logic [WORD_W-1:0] sig [BYTES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < BYTES; b++) sig[b] <= '0;
    end else if (wr_en) begin
      for (int b = 0; b < BYTES; b++)
        if (addr == ADDR_W'(b)) sig[b] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int b = 0; b < BYTES; b++)
      if (addr == ADDR_W'(b)) rd_data = sig[b];
  end

endmodule

// File: rtl/cfg_lock_store.sv
module cfg_lock_store
  import cfg_lock_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int WORD_W    = 8,
  parameter int CFG_WORDS = 40,
  parameter int NREG      = 10,
  parameter int SIG_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [OP_W-1:0]   cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [WORD_W-1:0] cmd_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [WORD_W-1:0] rsp_data,
  output logic              rsp_err,
  output logic              busy,
  output logic              locked,
  output logic [NREG-1:0]   preload_q
);

  localparam logic [ADDR_W-1:0] LAST_WORD = ADDR_W'(CFG_WORDS - 1);

  state_e            st_q;
  logic [ADDR_W-1:0] sweep_q;
  logic              lock_q;
  logic              rv_q;
  logic [WORD_W-1:0] rd_q;
  logic              re_q;
  logic [NREG-1:0]   pre_q;

  act_e              act;
  logic              accept;
  logic [WORD_W-1:0] pat_rd;
  logic [WORD_W-1:0] sig_rd;
  logic              sweeping;

  assign sweeping  = (st_q == ST_SWEEP);
  assign cmd_ready = !sweeping && !rv_q;
  assign accept    = cmd_valid && cmd_ready;

  cfg_lock_decode #(
    .ADDR_W(ADDR_W), .CFG_WORDS(CFG_WORDS), .NREG(NREG), .SIG_BYTES(SIG_BYTES)
  ) u_decode (
    .op(cmd_op), .addr(cmd_addr), .locked(lock_q), .act(act)
  );

  cfg_lock_pattern #(
    .WORDS(CFG_WORDS), .WORD_W(WORD_W), .ADDR_W(ADDR_W)
  ) u_pattern (
    .clk(clk), .rst_n(rst_n),
    .wr_en(accept && act == ACT_PAT_WR), .wr_addr(cmd_addr), .wr_data(cmd_wdata),
    .clr_en(sweeping), .clr_addr(sweep_q),
    .rd_addr(cmd_addr), .rd_data(pat_rd)
  );

  cfg_lock_signature #(
    .BYTES(SIG_BYTES), .WORD_W(WORD_W), .ADDR_W(ADDR_W)
  ) u_sig (
    .clk(clk), .rst_n(rst_n),
    .wr_en(accept && act == ACT_SIG_WR), .addr(cmd_addr), .wr_data(cmd_wdata),
    .rd_data(sig_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      sweep_q <= '0;
      lock_q  <= 1'b0;
      rv_q    <= 1'b0;
      rd_q    <= '0;
      re_q    <= 1'b0;
    end else begin
      if (rv_q && rsp_ready) rv_q <= 1'b0;
      if (sweeping) begin
        if (sweep_q == LAST_WORD) begin
          st_q   <= ST_IDLE;
          lock_q <= 1'b0;
          rv_q   <= 1'b1;
          rd_q   <= '0;
          re_q   <= 1'b0;
        end else begin
          sweep_q <= sweep_q + 1'b1;
        end
      end else if (accept) begin
        if (act == ACT_ERASE) begin
          st_q    <= ST_SWEEP;
          sweep_q <= '0;
        end else begin
          rv_q <= 1'b1;
          re_q <= (act == ACT_REFUSE);
          if (act == ACT_LOCK) lock_q <= 1'b1;
          case (act)
            ACT_PAT_RD: rd_q <= pat_rd;
            ACT_SIG_RD: rd_q <= sig_rd;
            default:    rd_q <= '0;
          endcase
        end
      end
    end
  end

  generate
    for (genvar i = 0; i < NREG; i++) begin : g_pre
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          pre_q[i] <= 1'b0;
        else if (accept && act == ACT_PRELOAD && cmd_addr == ADDR_W'(i))
          pre_q[i] <= cmd_wdata[0];
      end
    end
  endgenerate

  assign rsp_valid = rv_q;
  assign rsp_data  = rd_q;
  assign rsp_err   = re_q;
  assign busy      = sweeping;
  assign locked    = lock_q;
  assign preload_q = pre_q;

  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_err));

  // R9
  no_accept_while_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !cmd_ready);

  // R7
  no_accept_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cmd_ready);

  // R7
  erase_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> rsp_valid && !rsp_err && !locked);

  // R3
  locked_verify_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && locked && cmd_op == OP_PAT_RD |=> rsp_valid && rsp_err && rsp_data == '0);

  // R5
  locked_preload_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && locked && cmd_op == OP_PRELOAD |=> $stable(preload_q) && rsp_err);

  // R11
  lock_takes_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && cmd_op == OP_LOCK |=> locked && rsp_valid && !rsp_err);

  // R10
  rsp_next_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && cmd_op != OP_ERASE |=> rsp_valid);

endmodule

// File: tb/tb_cfg_lock_store.sv
module tb_cfg_lock_store;

  localparam int AW = 6;
  localparam int CW = 40;
  localparam int NR = 10;
  localparam int SB = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [3:0]    cmd_op = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic [7:0]    cmd_wdata = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b0;
  logic [7:0]    rsp_data;
  logic          rsp_err;
  logic          busy;
  logic          locked;
  logic [NR-1:0] preload_q;

  int n_chk = 0;
  int n_fail = 0;
  bit cmp_on = 0;

  always #2 clk = ~clk;

  cfg_lock_store dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rsp_err(rsp_err), .busy(busy), .locked(locked), .preload_q(preload_q)
  );

  // behavioural reference model
  int            m_pat [CW];
  int            m_sig [SB];
  logic [NR-1:0] m_pre;
  bit            m_lock, m_er, m_rv, m_re;
  int            m_rd, m_cnt;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic model_exec();
    int a = int'(cmd_addr);
    m_rv = 1; m_re = 0; m_rd = 0;
    case (cmd_op)
      4'd1: if (m_lock || a >= CW) m_re = 1; else m_pat[a] = int'(cmd_wdata);
      4'd2: if (m_lock || a >= CW) m_re = 1; else m_rd = m_pat[a];
      4'd3: if (m_lock || a >= NR) m_re = 1; else m_pre[a] = cmd_wdata[0];
      4'd4: if (a >= SB) m_re = 1; else m_sig[a] = int'(cmd_wdata);
      4'd5: if (a >= SB) m_re = 1; else m_rd = m_sig[a];
      4'd6: m_lock = 1;
      4'd7: begin m_er = 1; m_cnt = 0; m_rv = 0; end
      default: m_re = 1;
    endcase
  endtask

  always @(posedge clk) begin : model
    bit rdy;
    if (!rst_n) begin
      for (int i = 0; i < CW; i++) m_pat[i] = 0;
      for (int i = 0; i < SB; i++) m_sig[i] = 0;
      m_pre = '0; m_lock = 0; m_er = 0; m_rv = 0; m_re = 0; m_rd = 0; m_cnt = 0;
    end else begin
      rdy = !m_er && !m_rv;
      if (m_rv && rsp_ready) m_rv = 0;
      if (m_er) begin
        m_pat[m_cnt] = 0;
        if (m_cnt == CW - 1) begin
          m_er = 0; m_lock = 0; m_rv = 1; m_rd = 0; m_re = 0;
        end else m_cnt++;
      end else if (cmd_valid && rdy) model_exec();
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R9 cmd_ready", int'(cmd_ready), int'(!m_er && !m_rv));
      chk("R10 rsp_valid", int'(rsp_valid), int'(m_rv));
      if (m_rv) begin
        chk("R2 rsp_data", int'(rsp_data), m_rd);
        chk("R8 rsp_err", int'(rsp_err), int'(m_re));
      end
      chk("R7 busy", int'(busy), int'(m_er));
      chk("R3 locked", int'(locked), int'(m_lock));
      chk("R4 preload_q", int'(preload_q), int'(m_pre));
    end
  end

  task automatic send(input int op, input int addr, input int data);
    @(negedge clk);
    cmd_valid = 1; cmd_op = 4'(op); cmd_addr = AW'(addr); cmd_wdata = 8'(data);
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic get(input int exp_d, input int exp_e, input string tag, input int hold);
    chk({tag, " R10 latency"}, int'(rsp_valid), 1);
    repeat (hold) begin
      @(negedge clk);
      chk({tag, " R9 held"}, int'(rsp_valid), 1);
      chk({tag, " R9 ready low"}, int'(cmd_ready), 0);
    end
    chk({tag, " data"}, int'(rsp_data), exp_d);
    chk({tag, " err"}, int'(rsp_err), exp_e);
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
  endtask

  task automatic xfer(input int op, input int addr, input int data,
                      input int exp_d, input int exp_e, input string tag);
    send(op, addr, data);
    get(exp_d, exp_e, tag, 0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    cmp_on = 1;
    // R1 reset state
    chk("R1 cmd_ready", int'(cmd_ready), 1);
    chk("R1 rsp_valid", int'(rsp_valid), 0);
    chk("R1 locked", int'(locked), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 preload_q", int'(preload_q), 0);
    xfer(2, 3, 0, 8'h00, 0, "R1 pattern blank");
    xfer(5, 5, 0, 8'h00, 0, "R1 signature blank");

    // R2 pattern write/verify
    xfer(1, 0, 8'hA5, 0, 0, "R2 write w0");
    xfer(1, 3, 8'h3C, 0, 0, "R2 write w3");
    xfer(1, 39, 8'hFF, 0, 0, "R2 write w39");
    xfer(2, 0, 0, 8'hA5, 0, "R2 verify w0");
    xfer(2, 3, 0, 8'h3C, 0, "R2 verify w3");
    xfer(2, 39, 0, 8'hFF, 0, "R2 verify w39");

    // R8 out of range and undefined opcodes
    xfer(1, 40, 8'h12, 0, 1, "R8 write past end");
    xfer(2, 63, 0, 0, 1, "R8 verify past end");
    xfer(0, 0, 0, 0, 1, "R8 opcode 0");
    xfer(9, 1, 8'h55, 0, 1, "R8 opcode 9");
    xfer(2, 39, 0, 8'hFF, 0, "R8 w39 untouched");

    // R4 preload
    xfer(3, 2, 1, 0, 0, "R4 preload r2=1");
    chk("R4 preload after r2", int'(preload_q), 32'h004);
    xfer(3, 9, 8'hFF, 0, 0, "R4 preload r9=1");
    chk("R4 preload after r9", int'(preload_q), 32'h204);
    xfer(3, 2, 8'hFE, 0, 0, "R4 preload r2=0");
    chk("R4 preload clear r2", int'(preload_q), 32'h200);
    xfer(3, 10, 1, 0, 1, "R8 preload past end");
    chk("R8 preload unchanged", int'(preload_q), 32'h200);

    // R6 signature unlocked
    xfer(4, 0, 8'h11, 0, 0, "R6 sig write b0");
    xfer(4, 7, 8'hEE, 0, 0, "R6 sig write b7");
    xfer(5, 0, 0, 8'h11, 0, "R6 sig read b0");
    xfer(5, 7, 0, 8'hEE, 0, "R6 sig read b7");
    xfer(5, 8, 0, 0, 1, "R8 sig past end");

    // R9 back-pressure with a waiting command
    send(2, 3, 0);
    get(8'h3C, 0, "R9 stalled verify", 5);

    // R11 lock, R3 immediate effect
    xfer(6, 0, 0, 0, 0, "R11 lock");
    chk("R11 locked high", int'(locked), 1);
    xfer(2, 0, 0, 0, 1, "R3 verify refused");
    xfer(1, 5, 8'h99, 0, 1, "R3 write refused");
    xfer(3, 0, 1, 0, 1, "R5 preload refused");
    chk("R5 preload unchanged", int'(preload_q), 32'h200);
    xfer(5, 0, 0, 8'h11, 0, "R6 locked sig read");
    xfer(4, 3, 8'h77, 0, 0, "R6 locked sig write");
    xfer(5, 3, 0, 8'h77, 0, "R6 locked sig readback");
    xfer(6, 0, 0, 0, 0, "R11 relock");

    // R7 erase sweep
    begin
      int n = 0;
      send(7, 0, 0);
      while (busy) begin
        n++;
        @(negedge clk);
      end
      chk("R7 busy cycles", n, CW);
      get(0, 0, "R7 erase done", 0);
    end
    chk("R7 lock cleared", int'(locked), 0);
    chk("R7 preload kept", int'(preload_q), 32'h200);
    xfer(2, 0, 0, 0, 0, "R7 w0 blank");
    xfer(2, 39, 0, 0, 0, "R7 w39 blank");
    xfer(5, 7, 0, 8'hEE, 0, "R7 sig kept");
    xfer(1, 4, 8'h5A, 0, 0, "R2 write after erase");
    xfer(2, 4, 0, 8'h5A, 0, "R2 verify after erase");

    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule